// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointers

This block moves data words from one clock domain to another unrelated clock domain through a small register array. The producer side works in the write clock domain. It pushes a word with a write enable and watches a full flag. The consumer side works in the read clock domain. It sees the oldest stored word on its data output whenever the empty flag is low, and it pops that word with a read enable.

Each side keeps a binary pointer that addresses the array. Each side also keeps a Gray-coded copy of that pointer, one bit wider than the address. Only the Gray copy travels to the other domain, through a chain of synchronizer flops whose length is a parameter. Each flag is derived in its own domain from the local pointer and the delayed copy of the remote pointer. Because that copy is late, a flag may stay set a little longer than the true occupancy requires, but it is never cleared too soon. Each domain has its own active-low asynchronous reset. `DEPTH` must be a power of two and at least 4, and `SYNC_STAGES` must be 2 or 3.

Top module: `xclk_fifo`

## Requirements
- R1: After both resets, rd_empty_o is 1 and wr_full_o is 0.
- R2: Words leave in the order they were accepted. While rd_empty_o is 0, rd_data_o shows the oldest unread word without a read enable (show-ahead). Ordering holds across many pointer wraps.
- R3: Starting empty with the read side idle, wr_full_o stays 0 for the first DEPTH accepted writes and is 1 right after the DEPTH-th write edge.
- R4: A write enable while wr_full_o is 1 is ignored. The write pointer and the stored words do not change, so the words read out afterwards are exactly the DEPTH words accepted before.
- R5: A read enable while rd_empty_o is 1 is ignored. The read pointer does not move, so the next word written is the next word read.
- R6: After a write into an empty FIFO, rd_empty_o stays 1 through the first SYNC_STAGES-1 rising read-clock edges that follow the write edge. It clears after the SYNC_STAGES-th such edge, provided the two clocks never share an edge.
- R7: After a read from a full FIFO, wr_full_o stays 1 through the first SYNC_STAGES-1 rising write-clock edges that follow the read edge. It clears after the SYNC_STAGES-th such edge.
- R8: Each Gray pointer changes in at most one bit per clock of its domain. An accepted operation always advances its pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write domain clock |
| wr_rst_ni | input | 1 | Write domain asynchronous reset, active low |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | DATA_W | Word to push |
| wr_full_o | output | 1 | No room; pushes are dropped |
| rd_clk_i | input | 1 | Read domain clock |
| rd_rst_ni | input | 1 | Read domain asynchronous reset, active low |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | DATA_W | Oldest stored word |
| rd_empty_o | output | 1 | Nothing stored; pops are dropped |

## Verification
A push and a pop can land in the same instant of real time, one in each domain. Each side then sees the other's pointer only after the synchronizer delay. The streaming phase provokes this on purpose: the write clock runs faster than the read clock, and both sides use irregular enable patterns, so the FIFO repeatedly hits full while reads are draining it. Every popped word is compared with an arithmetic sequence, so a flag released too early shows up as a lost, repeated or stale word. The flag-latency cases use clocks whose edges never coincide, and they count edges exactly.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // Reflected binary code of a 32-bit value; callers truncate to pointer width
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xclk_fifo_wr_ctrl.sv
module xclk_fifo_wr_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  rd_gray_sync_i,
  output logic              full_o,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o
);
  logic [PTR_W-1:0] bin_q, bin_d, gray_q, gray_d, rd_far;

  // Read pointer one lap behind: top two Gray bits flipped
  assign rd_far = {~rd_gray_sync_i[PTR_W-1 -: 2], rd_gray_sync_i[PTR_W-3:0]};
  assign full_o = (gray_q == rd_far);
  assign fire_o = wr_en_i & ~full_o;
  assign bin_d  = bin_q + PTR_W'(fire_o);
  assign gray_d = PTR_W'(bin2gray(32'(bin_d)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];
  assign gray_o = gray_q;
endmodule

// File: rtl/xclk_fifo_rd_ctrl.sv
module xclk_fifo_rd_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  wr_gray_sync_i,
  output logic              empty_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o
);
  logic [PTR_W-1:0] bin_q, bin_d, gray_q, gray_d;
  logic             fire;

  assign empty_o = (gray_q == wr_gray_sync_i);
  assign fire    = rd_en_i & ~empty_o;
  assign bin_d   = bin_q + PTR_W'(fire);
  assign gray_d  = PTR_W'(bin2gray(32'(bin_d)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];
  assign gray_o = gray_q;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(DEPTH),
  localparam int unsigned PTR_W      = ADDR_W + 1
) (
  input  logic              wr_clk_i,
  input  logic              wr_rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  input  logic              rd_clk_i,
  input  logic              rd_rst_ni,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o
);
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_fire;

  xclk_fifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .wr_en_i(wr_en_i),
    .rd_gray_sync_i(rd_gray_ws), .full_o(wr_full_o), .fire_o(wr_fire),
    .addr_o(wr_addr), .gray_o(wr_gray)
  );

  xclk_fifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .rd_en_i(rd_en_i),
    .wr_gray_sync_i(wr_gray_rs), .empty_o(rd_empty_o),
    .addr_o(rd_addr), .gray_o(rd_gray)
  );

  xclk_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .d_i(wr_gray), .q_o(wr_gray_rs)
  );

  xclk_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .d_i(rd_gray), .q_o(rd_gray_ws)
  );

  xclk_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i(wr_clk_i), .we_i(wr_fire), .waddr_i(wr_addr), .wdata_i(wr_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int unsigned PTR_W = 4
) (
  input logic             wr_clk_i,
  input logic             wr_rst_ni,
  input logic             wr_en_i,
  input logic             wr_full_o,
  input logic [PTR_W-1:0] wr_gray,
  input logic             rd_clk_i,
  input logic             rd_rst_ni,
  input logic             rd_en_i,
  input logic             rd_empty_o,
  input logic [PTR_W-1:0] rd_gray
);
  assert_no_overflow_R4: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    (wr_en_i && wr_full_o) |=> $stable(wr_gray));

  assert_no_underflow_R5: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    (rd_en_i && rd_empty_o) |=> $stable(rd_gray));

  assert_wr_gray_step_R8: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_rd_gray_step_R8: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  assert_wr_advance_R8: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    (wr_en_i && !wr_full_o) |=> (wr_gray != $past(wr_gray)));

  assert_rd_advance_R8: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    (rd_en_i && !rd_empty_o) |=> (rd_gray != $past(rd_gray)));
endmodule

bind xclk_fifo xclk_fifo_chk #(.PTR_W(PTR_W)) u_chk (
  .wr_clk_i(wr_clk_i), .wr_rst_ni(wr_rst_ni), .wr_en_i(wr_en_i),
  .wr_full_o(wr_full_o), .wr_gray(wr_gray),
  .rd_clk_i(rd_clk_i), .rd_rst_ni(rd_rst_ni), .rd_en_i(rd_en_i),
  .rd_empty_o(rd_empty_o), .rd_gray(rd_gray)
);

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int SYNC = 2;
  localparam int NSTREAM = 200;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b1, rd_rst_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // 100 MHz write clock, 12 ns read clock: rising edges at odd vs even ns, never shared
  always #5 wr_clk = ~wr_clk;
  always #6 rd_clk = ~rd_clk;

  xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) uut (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(wr_full), .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_empty_o(rd_empty)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge wr_clk);
    wr_en <= 1'b0;
  endtask

  task automatic pop_check(input logic [DW-1:0] exp, input string req);
    @(negedge rd_clk);
    chk(!rd_empty, req, 32'(rd_empty), 0);
    chk(rd_data == exp, req, 32'(rd_data), 32'(exp));
    rd_en = 1'b1;
    @(posedge rd_clk);
    rd_en <= 1'b0;
  endtask

  initial begin
    #1;
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    #30;
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R1 empty", 32'(rd_empty), 1);
    @(negedge wr_clk);
    chk(wr_full == 1'b0, "R1 full", 32'(wr_full), 0);

    // R3: fill to capacity
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wr_clk);
      chk(wr_full == 1'b0, "R3 not full before fill", 32'(wr_full), 0);
      push(pat(i));
    end
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R3 full after DEPTH writes", 32'(wr_full), 1);

    // R4: writes while full are dropped
    for (int i = 0; i < 3; i++) push(8'hEE);
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R4 still full", 32'(wr_full), 1);

    // R7: one read from full, count write edges until full clears
    @(negedge rd_clk);
    chk(rd_data == pat(0), "R2 head", 32'(rd_data), 32'(pat(0)));
    rd_en = 1'b1;
    @(posedge rd_clk);
    rd_en <= 1'b0;
    for (int e = 0; e < SYNC - 1; e++) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R7 full held", 32'(wr_full), 1);
    @(posedge wr_clk);
    @(negedge wr_clk);
    chk(wr_full == 1'b0, "R7 full released", 32'(wr_full), 0);

    // R2/R4: remaining contents are the accepted words only
    for (int i = 1; i < DEPTH; i++) pop_check(pat(i), "R4 R2 drain");
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R2 empty after drain", 32'(rd_empty), 1);

    // R5: reads while empty are dropped
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (3) @(posedge rd_clk);
    rd_en <= 1'b0;
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R5 still empty", 32'(rd_empty), 1);

    // R6: write into empty, count read edges until empty clears
    push(8'h5A);
    for (int e = 0; e < SYNC - 1; e++) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R6 empty held", 32'(rd_empty), 1);
    @(posedge rd_clk);
    @(negedge rd_clk);
    chk(rd_empty == 1'b0, "R6 empty released", 32'(rd_empty), 0);
    pop_check(8'h5A, "R5 next write is next read");
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R5 empty again", 32'(rd_empty), 1);

    // R2/R3: concurrent streaming, many wraps, full reached under load
    begin
      int saw_full = 0;
      fork
        begin
          int i = 0, t = 0;
          while (i < NSTREAM) begin
            @(negedge wr_clk);
            t++;
            if (t % 5 == 4) wr_en = 1'b0;
            else begin
              wr_en = 1'b1;
              wr_data = pat(1000 + i);
              if (!wr_full) i++;
              else saw_full++;
            end
          end
          @(negedge wr_clk);
          wr_en = 1'b0;
        end
        begin
          int j = 0, t = 0;
          while (j < NSTREAM) begin
            @(negedge rd_clk);
            t++;
            rd_en = 1'b0;
            if (t % 3 != 0) begin
              rd_en = 1'b1;
              if (!rd_empty) begin
                chk(rd_data == pat(1000 + j), "R2 stream order",
                    32'(rd_data), 32'(pat(1000 + j)));
                j++;
              end
            end
          end
          @(negedge rd_clk);
          rd_en = 1'b0;
        end
      join
      chk(saw_full > 0, "R3 full seen in stream", 32'(saw_full), 1);
    end
    repeat (6) @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R2 empty after stream", 32'(rd_empty), 1);
    repeat (6) @(negedge wr_clk);
    chk(wr_full == 1'b0, "R3 not full after stream", 32'(wr_full), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R2 act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule